// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block keeps a configuration image of parameterised size in an internal byte array. It sends the image out one bit per rising clock edge on a serial data line. The line is modelled as a data value plus a drive-enable flag, which stands in for a tri-state pin. A combined output-enable/reset input clears the bit position and silences the line. An active-low select gates the counting. When the last stored bit has been consumed, an active-low cascade output asserts and the block stops driving the line. The cascade output is meant to be tied to the select of the next instance, so that several instances can form one continuous stream.

Which level of the output-enable/reset input counts as "reset" is chosen by a stored polarity bit. A simple synchronous byte write port loads the image and that polarity bit. After the power-up reset is released, a short settling interval runs. During that interval the ready flag is low and the streamer does nothing.

The control is a five-state machine:
- PWRUP: waits for ready.
- CLEAR: the output-enable/reset input is at its reset level.
- PAUSE: the select is high.
- SHIFT: bits are streaming.
- CASC: the image is exhausted and the block hands off.

Its transitions are:
- PWRUP goes to CLEAR once ready is set.
- Any state except PWRUP goes to CLEAR while the reset level is applied.
- CLEAR, PAUSE and SHIFT go to PAUSE when the select is high.
- CLEAR, PAUSE and SHIFT go to CASC when the last bit is consumed, and to SHIFT otherwise.
- CASC stays in CASC until the reset level is applied.

Top module: `cfg_bitstream_streamer`

## Requirements
- R1: While `rst_n` is low and for PWRUP_CYCLES rising edges after its release, `ready` is 0. After those edges `ready` is 1 and stays 1. While `ready` is 0, `ser_oe` is 0 and `casc_n` is 1.
- R2: While `oe_rst` is at its reset level, `ser_oe` is 0 whatever the level of `cs_n`. A rising edge at that level returns the bit position to 0 and releases `casc_n` to 1, so the next stream starts again at bit 0.
- R3: With `oe_rst` inactive and `cs_n` high, `ser_oe` is 0 and the bit position does not change. When `cs_n` returns low, streaming resumes at the same bit.
- R4: While `ser_oe` is 1, `ser_data` shows stream bit k, where k is the current bit position. Bit k is bit (k mod 8) of byte (k div 8), so each byte goes out least significant bit first. Each rising edge with `ser_oe` at 1 moves the position on by one.
- R5: The rising edge that consumes the final bit (k = 8*IMG_BYTES-1) drives `casc_n` to 0 and `ser_oe` to 0. Both stay that way, whatever `cs_n` does, until a reset level is applied on `oe_rst`.
- R6: The polarity bit is written as bit 0 of the byte written at `wr_addr` = IMG_BYTES. Its value is 0 after `rst_n`. A value of 0 makes a low `oe_rst` the reset level, and a value of 1 makes a high `oe_rst` the reset level.
- R7: A rising edge with `wr_en` high and `wr_addr` < IMG_BYTES stores `wr_data` as image byte `wr_addr`.
- R8: `ser_data` is 0 whenever `ser_oe` is 0.
- R9: When the `casc_n` of one instance drives the `cs_n` of a second instance that shares clock and `oe_rst`, the second starts driving its bit 0 in the cycle right after the first instance's final bit. Exactly one of the two drives the line at any time, until both are exhausted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stream clock; rising edges advance the bit position |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | $clog2(IMG_BYTES+1) | Image byte index, or IMG_BYTES for the polarity bit |
| wr_data | input | 8 | Byte to store |
| oe_rst | input | 1 | Output-enable / reset input, reset level set by the polarity bit |
| cs_n | input | 1 | Active-low select that gates counting and driving |
| ser_data | output | 1 | Serial data value |
| ser_oe | output | 1 | Drive enable of the serial data line |
| casc_n | output | 1 | Active-low cascade output, low once the image is exhausted |
| ready | output | 1 | High once the power-up interval is complete |

## Verification
The main function is tried with three stimulus patterns:

1. An uninterrupted two-instance chain streams two different images back to back. Its value is in separating bit ordering and hand-off timing errors, such as a lost or repeated bit at the boundary or an early cascade, from plain data errors.
2. A stream is broken mid-way by a select pause and then by a reset-level pulse. This tells "frozen position" apart from "restarted position".
3. A stream is run under the inverted reset polarity, followed by a rewritten first byte. This shows that the reset level really follows the stored bit, and that a write lands in the image that is read out.

// File: rtl/cfgs_pkg.sv
`timescale 1ns/1ps
package cfgs_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_CLEAR,
        ST_PAUSE,
        ST_SHIFT,
        ST_CASC
    } strm_state_t;

endpackage

// File: rtl/cfgs_pwrup_timer.sv
`timescale 1ns/1ps
module cfgs_pwrup_timer #(
    parameter int PWRUP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(PWRUP_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt_q == CW'(PWRUP_CYCLES - 1)) begin
                ready <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1: once set, ready never drops without a power-up reset
    a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

endmodule

// File: rtl/cfgs_image_mem.sv
`timescale 1ns/1ps
module cfgs_image_mem #(
    parameter int IMG_BYTES = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(IMG_BYTES+1)-1:0]     wr_addr,
    input  logic [7:0]                         wr_data,
    input  logic [$clog2(IMG_BYTES*8)-1:0]     rd_bit_idx,
    output logic                               rd_bit,
    output logic                               rst_pol_hi
);
    localparam int WR_AW   = $clog2(IMG_BYTES + 1);
    localparam int BIT_AW  = $clog2(IMG_BYTES * 8);
    localparam int BYTE_AW = BIT_AW - 3;

    logic [7:0] img_q [IMG_BYTES];

    logic [BYTE_AW-1:0] rd_byte;
    logic [2:0]         rd_sel;

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < WR_AW'(IMG_BYTES))) begin
            img_q[wr_addr[BYTE_AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_pol_hi <= 1'b0;
        end else if (wr_en && (wr_addr == WR_AW'(IMG_BYTES))) begin
            rst_pol_hi <= wr_data[0];
        end
    end

    always_comb begin
        rd_byte = rd_bit_idx[BIT_AW-1:3];
        rd_sel  = rd_bit_idx[2:0];
        rd_bit  = img_q[rd_byte][rd_sel];
    end

endmodule

// File: rtl/cfgs_stream_fsm.sv
`timescale 1ns/1ps
module cfgs_stream_fsm
    import cfgs_pkg::*;
#(
    parameter int IMG_BITS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ready,
    input  logic                        rst_act,
    input  logic                        cs_n,
    output logic [$clog2(IMG_BITS)-1:0] bit_idx,
    output logic                        run,
    output logic                        casc
);
    localparam int BIT_AW = $clog2(IMG_BITS);
    localparam logic [BIT_AW-1:0] LAST_IDX = BIT_AW'(IMG_BITS - 1);

    strm_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: begin
                if (ready) state_d = ST_CLEAR;
            end
            ST_CLEAR, ST_PAUSE, ST_SHIFT: begin
                if (rst_act)                state_d = ST_CLEAR;
                else if (cs_n)              state_d = ST_PAUSE;
                else if (bit_idx == LAST_IDX) state_d = ST_CASC;
                else                        state_d = ST_SHIFT;
            end
            ST_CASC: begin
                if (rst_act) state_d = ST_CLEAR;
            end
            default: state_d = ST_PWRUP;
        endcase
    end

    // outputs
    always_comb begin
        run  = 1'b0;
        casc = 1'b0;
        unique case (state_q)
            ST_PWRUP: ;
            ST_CLEAR, ST_PAUSE, ST_SHIFT: run = !rst_act && !cs_n;
            ST_CASC: casc = 1'b1;
            default: ;
        endcase
    end

    // bit position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if ((state_q == ST_PWRUP) || rst_act) begin
            bit_idx <= '0;
        end else if (run && (bit_idx != LAST_IDX)) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // R1: nothing leaves the power-up state before ready
    a_r1_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (state_q == ST_PWRUP));

    // R2: a reset level clears position and cascade
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_act && state_q != ST_PWRUP) |=> (bit_idx == '0 && state_q == ST_CLEAR));

    // R3: select high freezes the position
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PWRUP && !rst_act && cs_n) |=> $stable(bit_idx));

    // R4: each driving edge steps the position by one
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_idx != LAST_IDX) |=> (bit_idx == $past(bit_idx) + 1'b1));

    // R5: the exhausted state holds until a reset level
    a_r5_casc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CASC && !rst_act) |=> (state_q == ST_CASC));

endmodule

// File: rtl/cfg_bitstream_streamer.sv
`timescale 1ns/1ps
module cfg_bitstream_streamer #(
    parameter int IMG_BYTES    = 8,
    parameter int PWRUP_CYCLES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(IMG_BYTES+1)-1:0] wr_addr,
    input  logic [7:0]                     wr_data,
    input  logic                           oe_rst,
    input  logic                           cs_n,
    output logic                           ser_data,
    output logic                           ser_oe,
    output logic                           casc_n,
    output logic                           ready
);
    localparam int IMG_BITS = IMG_BYTES * 8;
    localparam int BIT_AW   = $clog2(IMG_BITS);

    logic [BIT_AW-1:0] bit_idx;
    logic              rd_bit;
    logic              rst_pol_hi;
    logic              rst_act;
    logic              run;
    logic              casc;

    cfgs_pwrup_timer #(
        .PWRUP_CYCLES (PWRUP_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    cfgs_image_mem #(
        .IMG_BYTES (IMG_BYTES)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_bit_idx (bit_idx),
        .rd_bit     (rd_bit),
        .rst_pol_hi (rst_pol_hi)
    );

    // reset level of oe_rst equals the stored polarity bit
    assign rst_act = (oe_rst == rst_pol_hi);

    cfgs_stream_fsm #(
        .IMG_BITS (IMG_BITS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .rst_act (rst_act),
        .cs_n    (cs_n),
        .bit_idx (bit_idx),
        .run     (run),
        .casc    (casc)
    );

    assign ser_oe   = run;
    assign ser_data = run & rd_bit;
    assign casc_n   = ~casc;

    // R1: quiet line and released cascade before ready
    a_r1_pwrup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!ser_oe && casc_n));

    // R5: no drive once the cascade output is asserted
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_n |-> !ser_oe);

    // R8: data value parked at zero when not driving
    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_oe |-> !ser_data);

endmodule

// File: tb/cfg_bitstream_streamer_tb_top.sv
`timescale 1ns/1ps
module cfg_bitstream_streamer_tb_top;

    localparam int NB   = 8;
    localparam int NBIT = NB * 8;
    localparam int PWR  = 4;
    localparam int AW   = $clog2(NB + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n  = 1'b0;
    logic          oe_rst = 1'b0;
    logic          cs_n   = 1'b1;
    logic          we1    = 1'b0;
    logic          we2    = 1'b0;
    logic [AW-1:0] waddr  = '0;
    logic [7:0]    wdata  = '0;

    logic d1, o1, c1, r1;
    logic d2, o2, c2, r2;

    int checks = 0;
    int errors = 0;

    logic [7:0] img [2][NB];

    cfg_bitstream_streamer #(.IMG_BYTES(NB), .PWRUP_CYCLES(PWR)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_addr(waddr), .wr_data(wdata),
        .oe_rst(oe_rst), .cs_n(cs_n),
        .ser_data(d1), .ser_oe(o1), .casc_n(c1), .ready(r1));

    cfg_bitstream_streamer #(.IMG_BYTES(NB), .PWRUP_CYCLES(PWR)) dut_chain_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we2), .wr_addr(waddr), .wr_data(wdata),
        .oe_rst(oe_rst), .cs_n(c1),
        .ser_data(d2), .ser_oe(o2), .casc_n(c2), .ready(r2));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        #2;
    endtask

    function automatic int eb(input int dev, input int k);
        return int'(img[dev][k / 8][k % 8]);
    endfunction

    task automatic wr(input int dev, input int a, input logic [7:0] v);
        waddr = AW'(a);
        wdata = v;
        we1   = (dev == 0);
        we2   = (dev == 1);
        nxt();
        we1 = 1'b0;
        we2 = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) nxt();
        chk("R1 ready in reset", int'(r1), 0);
        chk("R1 oe in reset", int'(o1), 0);
        chk("R1 casc in reset", int'(c1), 1);
        rst_n = 1'b1;
        for (int i = 1; i <= PWR; i++) begin
            nxt();
            chk("R1 ready after release", int'(r1), (i < PWR) ? 0 : 1);
            if (i < PWR) chk("R1 quiet before ready", int'(o1), 0);
        end
    endtask

    task automatic t_load();
        for (int i = 0; i < NB; i++) begin
            img[0][i] = 8'(i * 29 + 8'hA5);
            img[1][i] = 8'(i * 53 + 8'h3C);
            wr(0, i, img[0][i]);
            wr(1, i, img[1][i]);
        end
    endtask

    task automatic t_chain();
        cs_n = 1'b0;
        #2;
        chk("R2 oe with cs low at reset level", int'(o1), 0);
        nxt();
        oe_rst = 1'b1;
        #2;
        for (int k = 0; k < 2 * NBIT; k++) begin
            if (k < NBIT) begin
                chk("R4 first drives", int'(o1), 1);
                chk("R4 first bit", int'(d1), eb(0, k));
                chk("R9 second silent", int'(o2), 0);
                chk("R5 casc not early", int'(c1), 1);
            end else begin
                chk("R9 first silent", int'(o1), 0);
                chk("R8 first parked", int'(d1), 0);
                chk("R5 first cascaded", int'(c1), 0);
                chk("R9 second drives", int'(o2), 1);
                chk("R9 second bit", int'(d2), eb(1, k - NBIT));
            end
            nxt();
        end
        chk("R5 first casc end", int'(c1), 0);
        chk("R5 second casc end", int'(c2), 0);
        chk("R5 first oe end", int'(o1), 0);
        chk("R9 second oe end", int'(o2), 0);
    endtask

    task automatic t_casc_hold();
        for (int i = 0; i < 6; i++) begin
            cs_n = (i < 3);
            nxt();
            chk("R5 casc held", int'(c1), 0);
            chk("R5 no drive held", int'(o1), 0);
        end
    endtask

    task automatic t_oe_reset();
        oe_rst = 1'b0;
        #2;
        chk("R2 oe dropped", int'(o1), 0);
        nxt();
        chk("R2 casc released", int'(c1), 1);
        chk("R2 chain casc released", int'(c2), 1);
        oe_rst = 1'b1;
        #2;
        for (int k = 0; k < 10; k++) begin
            chk("R2 restart bit", int'(d1), eb(0, k));
            nxt();
        end
        oe_rst = 1'b0;
        #2;
        chk("R2 midstream oe", int'(o1), 0);
        nxt();
        oe_rst = 1'b1;
        #2;
        chk("R2 back to bit0 oe", int'(o1), 1);
        chk("R2 back to bit0", int'(d1), eb(0, 0));
    endtask

    task automatic t_pause();
        for (int k = 0; k < 5; k++) nxt();
        cs_n = 1'b1;
        #2;
        chk("R3 oe paused", int'(o1), 0);
        chk("R8 data paused", int'(d1), 0);
        for (int i = 0; i < 3; i++) begin
            nxt();
            chk("R3 oe still paused", int'(o1), 0);
            chk("R3 no cascade in pause", int'(c1), 1);
        end
        cs_n = 1'b0;
        #2;
        chk("R3 resume oe", int'(o1), 1);
        chk("R3 resume bit5", int'(d1), eb(0, 5));
        nxt();
        chk("R3 then bit6", int'(d1), eb(0, 6));
    endtask

    task automatic t_polarity_and_write();
        wr(0, NB, 8'h01);
        chk("R6 high level now resets", int'(o1), 0);
        nxt();
        oe_rst = 1'b0;
        #2;
        chk("R6 low level enables", int'(o1), 1);
        chk("R6 bit0 under inverted", int'(d1), eb(0, 0));
        nxt();
        chk("R6 bit1 under inverted", int'(d1), eb(0, 1));
        wr(0, NB, 8'h00);
        chk("R6 low level resets again", int'(o1), 0);
        img[0][0] = 8'h0F;
        wr(0, 0, 8'h0F);
        nxt();
        oe_rst = 1'b1;
        #2;
        for (int k = 0; k < 8; k++) begin
            chk("R7 rewritten byte bit", int'(d1), eb(0, k));
            nxt();
        end
    endtask

    initial begin
        #2;
        t_reset();
        t_load();
        t_chain();
        t_casc_hold();
        t_oe_reset();
        t_pause();
        t_polarity_and_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule